// File: doc/BRIEF.md
# Cascaded interrupt mask controller

This block gathers level-sensitive interrupt sources into two local levels of eight bits. Each level has a live status byte and a mask byte. A level's request to the processor is raised while any status bit that is also enabled in its mask is high. A third group of eight mapped sources is shared by both levels. Two independent map masks each qualify that one shared status byte. The result of each map mask drives a single cascade bit inside its own local level, so one mapped source can be routed to level 0, level 1, both, or neither.

Software reaches the four mask bytes and the three status bytes through a single-cycle register port. A write carries an address, a data byte and an operation: overwrite, set bits, or clear bits. A read returns data combinationally in the same cycle. The cascade bit of each local mask belongs to the map-mask path. It is set whenever its map mask is non-zero and cleared only when that map mask has become entirely zero. A write to the local mask never changes it.

The block builds an eight-line request vector for the processor. The two local levels drive lines 2 and 3. Two timer requests, a bus-error request and a count/compare request pass straight through to lines 4 to 7. The two software lines are held low.

Top module: `casc_irq_ctrl`

## Requirements
- R1: The status bytes of both local levels and of the mapped group sample their input pins on every clock edge, with no latching. They are read at address 4 (level 0), 5 (level 1) and 6 (mapped). In a local status byte, the bit at the cascade position (bit 7) ignores its input pin. It shows instead whether the mapped status AND that level's map mask is non-zero.
- R2: Line 2 of `cpu_irq` is the OR of (level 0 status AND level 0 mask), and line 3 is the same for level 1. Both lines follow an input change one clock edge later.
- R3: A register write applies its data according to the operation code: 0 overwrites, 1 sets the bits that are 1 in the data, 2 clears the bits that are 1 in the data, and 3 leaves the register unchanged. The address map is 0 for local mask 0, 1 for local mask 1, 2 for map mask 0 and 3 for map mask 1. The new value is visible after the clock edge.
- R4: A write to a local mask, with any operation, leaves that mask's cascade bit (bit 7) unchanged. The other bits of the mask change only as R3 describes.
- R5: A write that leaves a map mask non-zero sets the cascade bit (bit 7) of the matching local mask.
- R6: Clearing map-mask bits clears the matching local mask's cascade bit only once the whole map mask is zero. While any map-mask bit remains, the cascade bit stays set.
- R7: The shared mapped status is qualified separately by each map mask. Level 0's cascade uses map mask 0 and level 1's cascade uses map mask 1.
- R8: Reset clears both local masks and both map masks, so lines 2 and 3 are low after reset.
- R9: Lines 4, 5, 6 and 7 of `cpu_irq` follow the timer-0, timer-1, bus-error and count/compare inputs combinationally. Lines 0 and 1 are always low.
- R10: Reads return data in the same cycle as the address is presented. Writes to addresses 4 to 7 change no register. A read of address 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl0_src | input | 8 | Level-sensitive sources of local level 0 |
| lvl1_src | input | 8 | Level-sensitive sources of local level 1 |
| map_src | input | 8 | Shared mapped sources |
| tmr0_req | input | 1 | Timer 0 request |
| tmr1_req | input | 1 | Timer 1 request |
| berr_req | input | 1 | Bus-error request |
| cmp_req | input | 1 | Count/compare timer request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_op | input | 2 | Write operation: 0 overwrite, 1 set, 2 clear, 3 none |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| cpu_irq | output | 8 | Request lines to the processor |

## Verification
Several properties are checked on every cycle. Each cascade bit must track whether its map mask is non-zero. Each level request must equal the OR of sampled status and mask, with the cascade term using that level's own map mask. Local-mask writes must leave the cascade bit alone. The status bytes must follow their pins one edge late, and the pass-through and software lines must hold their fixed values. Some behaviour can only be shown by the bench's scenarios. These cover the arithmetic of the three write operations and the reserved operation, the ordered clearing of a map mask bit by bit, and writes to status and unused addresses having no effect. The bench also sweeps every source pattern against several mask settings and shows that one mapped source reaches the two levels independently.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NLVL   = 2;
    localparam int ADDR_W = 3;
    localparam int CPU_W  = 8;

    localparam int A_LMASK0 = 0;
    localparam int A_MMASK0 = 2;
    localparam int A_LSTAT0 = 4;
    localparam int A_MSTAT  = 6;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } reg_op_e;
endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
    import irqc_pkg::*;
#(
    parameter int W        = 8,
    parameter int CASC_BIT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [1:0]                 op_i,
    input  logic [W-1:0]               wdata_i,
    output logic [NLVL-1:0][W-1:0]     lmask_o,
    output logic [NLVL-1:0][W-1:0]     mmask_o
);
    typedef struct packed {
        logic [NLVL-1:0][W-1:0] lmask;
        logic [NLVL-1:0][W-1:0] mmask;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic [W-1:0] upd;

    function automatic logic [W-1:0] apply_op(input logic [1:0] op,
                                              input logic [W-1:0] old,
                                              input logic [W-1:0] data);
        case (reg_op_e'(op))
            OP_WRITE: apply_op = data;
            OP_SET:   apply_op = old | data;
            OP_CLR:   apply_op = old & ~data;
            default:  apply_op = old;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        upd  = '0;
        if (we_i) begin
            for (int l = 0; l < NLVL; l++) begin
                if (int'(addr_i) == A_LMASK0 + l) begin
                    // ordinary path: cascade bit is owned by the map path
                    upd           = apply_op(op_i, st_q.lmask[l], wdata_i);
                    upd[CASC_BIT] = st_q.lmask[l][CASC_BIT];
                    st_d.lmask[l] = upd;
                end
                if (int'(addr_i) == A_MMASK0 + l) begin
                    st_d.mmask[l]           = apply_op(op_i, st_q.mmask[l], wdata_i);
                    st_d.lmask[l][CASC_BIT] = |st_d.mmask[l];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lmask_o = st_q.lmask;
    assign mmask_o = st_q.mmask;
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
    parameter int W        = 8,
    parameter int CASC_BIT = 7
) (
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] map_stat_i,
    input  logic [W-1:0] map_mask_i,
    input  logic [W-1:0] lmask_i,
    output logic [W-1:0] stat_o,
    output logic         req_o
);
    logic casc_hit;

    always_comb begin
        casc_hit         = |(map_stat_i & map_mask_i);
        stat_o           = raw_i;
        stat_o[CASC_BIT] = casc_hit;
        req_o            = |(stat_o & lmask_i);
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int W        = 8,
    parameter int CASC_BIT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         lvl0_src,
    input  logic [W-1:0]         lvl1_src,
    input  logic [W-1:0]         map_src,
    input  logic                 tmr0_req,
    input  logic                 tmr1_req,
    input  logic                 berr_req,
    input  logic                 cmp_req,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [1:0]           reg_op,
    input  logic [W-1:0]         reg_wdata,
    output logic [W-1:0]         reg_rdata,
    output logic [CPU_W-1:0]     cpu_irq
);
    logic [NLVL-1:0][W-1:0] lraw;
    logic [NLVL-1:0][W-1:0] lstat;
    logic [NLVL-1:0][W-1:0] lmask;
    logic [NLVL-1:0][W-1:0] mmask;
    logic [W-1:0]           mstat;
    logic [NLVL-1:0]        lreq;
    logic [NLVL-1:0][W-1:0] src_bus;

    assign src_bus[0] = lvl0_src;
    assign src_bus[1] = lvl1_src;

    irqc_sampler #(.W(W)) u_map_smp (
        .clk(clk), .rst_n(rst_n), .src_i(map_src), .stat_o(mstat)
    );

    irqc_mask_regs #(.W(W), .CASC_BIT(CASC_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .op_i(reg_op), .wdata_i(reg_wdata), .lmask_o(lmask), .mmask_o(mmask)
    );

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        irqc_sampler #(.W(W)) u_smp (
            .clk(clk), .rst_n(rst_n), .src_i(src_bus[l]), .stat_o(lraw[l])
        );
        irqc_level #(.W(W), .CASC_BIT(CASC_BIT)) u_lvl (
            .raw_i(lraw[l]), .map_stat_i(mstat), .map_mask_i(mmask[l]),
            .lmask_i(lmask[l]), .stat_o(lstat[l]), .req_o(lreq[l])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (int'(reg_addr) == A_LMASK0 + l) reg_rdata = lmask[l];
            if (int'(reg_addr) == A_MMASK0 + l) reg_rdata = mmask[l];
            if (int'(reg_addr) == A_LSTAT0 + l) reg_rdata = lstat[l];
        end
        if (int'(reg_addr) == A_MSTAT) reg_rdata = mstat;
    end

    assign cpu_irq = {cmp_req, berr_req, tmr1_req, tmr0_req, lreq[1], lreq[0], 2'b00};
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int W        = 8,
    parameter int CASC_BIT = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [W-1:0]         lvl0_src,
    input logic [W-1:0]         lvl1_src,
    input logic                 tmr0_req,
    input logic                 tmr1_req,
    input logic                 berr_req,
    input logic                 cmp_req,
    input logic                 reg_we,
    input logic [2:0]           reg_addr,
    input logic [7:0]           cpu_irq,
    input logic [1:0][W-1:0]    lraw,
    input logic [1:0][W-1:0]    lmask,
    input logic [1:0][W-1:0]    mmask,
    input logic [W-1:0]         mstat
);
    logic [W-1:0] non_casc;
    assign non_casc = ~(W'(1) << CASC_BIT);

    p_casc0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lmask[0][CASC_BIT] == (|mmask[0]));
    p_casc1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lmask[1][CASC_BIT] == (|mmask[1]));
    p_req0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[2] == ((|(lraw[0] & lmask[0] & non_casc)) |
                       (lmask[0][CASC_BIT] & (|(mstat & mmask[0])))));
    p_req1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[3] == ((|(lraw[1] & lmask[1] & non_casc)) |
                       (lmask[1][CASC_BIT] & (|(mstat & mmask[1])))));
    p_local_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0) |=> $stable(lmask[0][CASC_BIT]));
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[7:4] == {cmp_req, berr_req, tmr1_req, tmr0_req});
    p_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq[1:0] == 2'b00);
    p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lmask == '0 && mmask == '0));
    p_stat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lraw[0] == $past(lvl0_src) && lraw[1] == $past(lvl1_src)));
endmodule

bind casc_irq_ctrl irqc_chk #(.W(W), .CASC_BIT(CASC_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .lvl0_src(lvl0_src), .lvl1_src(lvl1_src),
    .tmr0_req(tmr0_req), .tmr1_req(tmr1_req), .berr_req(berr_req), .cmp_req(cmp_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .cpu_irq(cpu_irq),
    .lraw(lraw), .lmask(lmask), .mmask(mmask), .mstat(mstat)
);

// File: tb/tb_casc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_casc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lvl0_src = '0, lvl1_src = '0, map_src = '0;
    logic       tmr0_req = 0, tmr1_req = 0, berr_req = 0, cmp_req = 0;
    logic       reg_we = 0;
    logic [2:0] reg_addr = '0;
    logic [1:0] reg_op = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] cpu_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_lm [2];
    logic [7:0] m_mm [2];

    always #2 clk = ~clk;

    casc_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .lvl0_src(lvl0_src), .lvl1_src(lvl1_src),
        .map_src(map_src), .tmr0_req(tmr0_req), .tmr1_req(tmr1_req),
        .berr_req(berr_req), .cmp_req(cmp_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_op(reg_op), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] op_val(input logic [1:0] op, input logic [7:0] o, input logic [7:0] d);
        case (op)
            2'd0: return d;
            2'd1: return o | d;
            2'd2: return o & ~d;
            default: return o;
        endcase
    endfunction

    // model update follows R3 to R6
    task automatic wr(input logic [2:0] a, input logic [1:0] op, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_op = op; reg_wdata = d;
        tick();
        reg_we = 0;
        if (a < 3'd2) begin
            logic [7:0] n;
            n = op_val(op, m_lm[a], d);
            n[7] = m_lm[a][7];
            m_lm[a] = n;
        end else if (a < 3'd4) begin
            m_mm[a-2] = op_val(op, m_mm[a-2], d);
            m_lm[a-2][7] = |m_mm[a-2];
        end
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    function automatic logic [7:0] exp_stat(input int l, input logic [7:0] src);
        logic [7:0] s;
        s = src;
        s[7] = |(map_src & m_mm[l]);
        return s;
    endfunction

    task automatic check_levels(input string req);
        chk({req, " line2"}, {7'd0, cpu_irq[2]}, {7'd0, |(exp_stat(0, lvl0_src) & m_lm[0])});
        chk({req, " line3"}, {7'd0, cpu_irq[3]}, {7'd0, |(exp_stat(1, lvl1_src) & m_lm[1])});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_lm[0] = 0; m_lm[1] = 0; m_mm[0] = 0; m_mm[1] = 0;
        repeat (3) tick();
        // R8: reset state with live sources present
        lvl0_src = 8'hFF; lvl1_src = 8'hFF; map_src = 8'hFF;
        rst_n = 1'b1;
        tick(); tick();
        chk("R8 lines", {6'd0, cpu_irq[3:2]}, 8'h00);
        for (int a = 0; a < 4; a++) rd("R8 mask", 3'(a), 8'h00);
        lvl0_src = 0; lvl1_src = 0; map_src = 0;
        tick();

        // R9: pass-through sweep, same cycle
        for (int v = 0; v < 16; v++) begin
            {cmp_req, berr_req, tmr1_req, tmr0_req} = 4'(v);
            #1;
            chk("R9 pass", {4'd0, cpu_irq[7:4]}, 8'(v));
            chk("R9 soft", {6'd0, cpu_irq[1:0]}, 8'h00);
        end
        {cmp_req, berr_req, tmr1_req, tmr0_req} = 4'h0;

        // R3: operations on local masks
        for (int l = 0; l < 2; l++) begin
            wr(3'(l), 2'd0, 8'h55); rd("R3 write", 3'(l), m_lm[l]);
            chk("R3 write val", m_lm[l], 8'h55);
            wr(3'(l), 2'd1, 8'h0A); rd("R3 set", 3'(l), 8'h5F);
            wr(3'(l), 2'd2, 8'h05); rd("R3 clear", 3'(l), 8'h5A);
            wr(3'(l), 2'd3, 8'hFF); rd("R3 none", 3'(l), 8'h5A);
        end

        // R4: local writes cannot reach the cascade bit
        wr(3'd0, 2'd0, 8'hFF); rd("R4 set blocked", 3'd0, 8'h7F);
        wr(3'd2, 2'd1, 8'h01); rd("R5 casc on", 3'd0, 8'hFF);
        wr(3'd0, 2'd0, 8'h00); rd("R4 clear blocked", 3'd0, 8'h80);
        wr(3'd0, 2'd2, 8'hFF); rd("R4 clr op blocked", 3'd0, 8'h80);

        // R5 / R6: ordered map-mask clearing
        wr(3'd2, 2'd1, 8'h02); rd("R5 map", 3'd2, 8'h03);
        wr(3'd2, 2'd2, 8'h01); rd("R6 partial", 3'd0, 8'h80);
        wr(3'd2, 2'd2, 8'h02); rd("R6 zero", 3'd0, 8'h00);
        wr(3'd3, 2'd0, 8'h10); rd("R5 write l1", 3'd1, 8'hDA);
        wr(3'd3, 2'd0, 8'h00); rd("R6 write zero l1", 3'd1, 8'h5A);

        // R10: status and unused addresses ignore writes, read 7 is zero
        wr(3'd4, 2'd0, 8'hFF); wr(3'd6, 2'd1, 8'hFF); wr(3'd7, 2'd0, 8'hFF);
        for (int a = 0; a < 4; a++) rd("R10 untouched", 3'(a), (a < 2) ? m_lm[a] : m_mm[a-2]);
        rd("R10 addr7", 3'd7, 8'h00);

        // R1 / R2: sweep every source pattern against several masks
        for (int k = 0; k < 4; k++) begin
            logic [7:0] mk;
            mk = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h7F : 8'h24;
            wr(3'd0, 2'd0, mk); wr(3'd1, 2'd0, ~mk);
            for (int s = 0; s < 256; s++) begin
                lvl0_src = 8'(s); lvl1_src = 8'(255 - s);
                tick();
                check_levels("R2");
                rd("R1 stat0", 3'd4, exp_stat(0, lvl0_src));
                rd("R1 stat1", 3'd5, exp_stat(1, lvl1_src));
            end
        end
        // R2: one-edge latency
        wr(3'd0, 2'd0, 8'h01); lvl0_src = 8'h00; tick();
        lvl0_src = 8'h01; #1;
        chk("R2 before edge", {7'd0, cpu_irq[2]}, 8'h00);
        tick();
        chk("R2 after edge", {7'd0, cpu_irq[2]}, 8'h01);

        // R7: shared map status, independent masks
        wr(3'd0, 2'd0, 8'h00); wr(3'd1, 2'd0, 8'h00);
        lvl0_src = 8'hFF; lvl1_src = 8'hFF;
        wr(3'd2, 2'd0, 8'h0F); wr(3'd3, 2'd0, 8'hF0);
        for (int s = 0; s < 256; s++) begin
            map_src = 8'(s);
            tick();
            check_levels("R7");
            rd("R7 mstat", 3'd6, 8'(s));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule